// File: doc/BRIEF.md
# Serial Memory Status and Write-Guard Unit

This unit sits beside the command decoder of a serial-bus memory slave. It holds the 8-bit status byte that the host reads back. It keeps the write-enable latch and the non-volatile-style protection settings: a register-lock flag and a 2-bit protected-region code. For every byte the host tries to store, it decides whether the store may go ahead. The decoder reports events to it as one-cycle pulses: enable and disable commands, a completed status-write data byte, and the end of each chip-select frame together with the kind of frame that is ending. The unit answers with two combinational permits, one for the array byte at the current burst address and one for the status register.

The protected region always sits at the top of the address space: the upper quarter, the upper half, or the whole array. The region code alone decides array protection. The register-lock flag together with a low write-protect pin can freeze only the status register. Any write also needs the enable latch to be set, and frames that perform a write consume the latch when they end. There are two resets. A soft reset drops only the latch and keeps the protection settings. A power-on reset clears everything.

Top module: `spi_status_guard`

## Requirements
- R1: The status byte is {lock flag at bit 7, zeros at bits 6:4, region code at bits 3:2, enable latch at bit 1, zero at bit 0}.
- R2: With 16-bit addresses, region code 2'b00 protects nothing, 2'b01 protects addresses 0xC000 and above, 2'b10 protects 0x8000 and above, and 2'b11 protects every address.
- R3: A pulse on `op_wren` sets the enable latch, and the latch is visible after the next clock edge.
- R4: A pulse on `op_wrdi` clears the latch. A `frame_end` pulse with `frame_kind` 1 (array write) or 2 (status write) also clears it. A frame end with kind 0 (e.g. a status read) leaves it unchanged. A clear wins over a set arriving in the same cycle.
- R5: `arr_wr_ok` is high exactly when the latch is set and `wr_addr` lies outside the protected region. Neither `wp_n` nor the lock flag affects it.
- R6: `sr_wr_ok` is low whenever the lock flag is 1 and `wp_n` is 0. An `sr_wr_valid` pulse while `sr_wr_ok` is high loads bit 7 into the lock flag and bits 3:2 into the region code. All other data bits are ignored. An `sr_wr_valid` pulse while `sr_wr_ok` is low changes nothing.
- R7: Both permits are low while the enable latch is clear, whatever the address or settings.
- R8: A low `rst_n` clears the latch but keeps the lock flag and region code. A low `por_n` clears the whole status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Soft reset, active low, clears only the enable latch |
| op_wren | input | 1 | Pulse: enable command received |
| op_wrdi | input | 1 | Pulse: disable command received |
| frame_end | input | 1 | Pulse: chip select has risen, frame over |
| frame_kind | input | 2 | Kind of ending frame: 0 other, 1 array write, 2 status write |
| sr_wr_valid | input | 1 | Pulse: status-write data byte complete |
| sr_wr_data | input | 8 | Status-write data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_addr | input | ADDR_W | Current burst address of the byte being written |
| status_byte | output | 8 | Status byte returned on a status read |
| wel | output | 1 | Enable latch state |
| arr_wr_ok | output | 1 | Array byte at `wr_addr` may be written |
| sr_wr_ok | output | 1 | Status register may be written |

## Verification
A wrong latch value shows on `status_byte[1]` and on both permits one edge after the event that caused it. Because the permits are combinational, a wrong region decode shows at once when `wr_addr` crosses a boundary. A lost or stray status update shows at bits 7 and 3:2 on the edge after the data pulse. State kept wrongly across a soft reset becomes visible as soon as that reset is released.

// File: rtl/spi_status_guard_pkg.sv
package spi_status_guard_pkg;

    typedef enum logic [1:0] {
        FK_OTHER  = 2'd0,
        FK_ARRAY  = 2'd1,
        FK_STATUS = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] region;
    } prot_t;

    localparam int unsigned SB_LOCK_BIT = 7;
    localparam int unsigned SB_RGN_HI   = 3;
    localparam int unsigned SB_RGN_LO   = 2;

endpackage

// File: rtl/ssg_region_cmp.sv
module ssg_region_cmp #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [1:0]        region,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] HALF_BASE    = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};

    always_comb begin
        case (region)
            2'b01:   hit = (addr >= QUARTER_BASE);
            2'b10:   hit = (addr >= HALF_BASE);
            2'b11:   hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ssg_enable_latch.sv
module ssg_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    logic wel_d, wel_q;

    always_comb begin
        wel_d = wel_q;
        if (set_i) wel_d = 1'b1;
        if (clr_i) wel_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wel_q <= 1'b0;
        else        wel_q <= wel_d;
    end

    assign wel_o = wel_q;
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import spi_status_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              op_wren,
    input  logic              op_wrdi,
    input  logic              frame_end,
    input  logic [1:0]        frame_kind,
    input  logic              sr_wr_valid,
    input  logic [7:0]        sr_wr_data,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        status_byte,
    output logic              wel,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok
);
    prot_t       prot_d, prot_q;
    frame_kind_e kind;
    logic        wel_rst_n;
    logic        wel_clr;
    logic        wel_q;
    logic        in_region;
    logic        sr_locked;
    logic        sr_data_unused;

    assign kind           = frame_kind_e'(frame_kind);
    assign wel_rst_n      = por_n & rst_n;
    assign wel_clr        = op_wrdi | (frame_end & ((kind == FK_ARRAY) | (kind == FK_STATUS)));
    assign sr_data_unused = ^{sr_wr_data[6:4], sr_wr_data[1:0]};

    ssg_enable_latch u_latch (
        .clk   (clk),
        .rst_n (wel_rst_n),
        .set_i (op_wren),
        .clr_i (wel_clr),
        .wel_o (wel_q)
    );

    ssg_region_cmp #(.ADDR_W(ADDR_W)) u_region (
        .region (prot_q.region),
        .addr   (wr_addr),
        .hit    (in_region)
    );

    assign sr_locked = prot_q.lock & ~wp_n;

    always_comb begin
        prot_d = prot_q;
        if (sr_wr_valid && wel_q && !sr_locked) begin
            prot_d.lock   = sr_wr_data[SB_LOCK_BIT];
            prot_d.region = sr_wr_data[SB_RGN_HI:SB_RGN_LO];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prot_q <= '0;
        else        prot_q <= prot_d;
    end

    assign status_byte = {prot_q.lock, 3'b000, prot_q.region, wel_q, 1'b0};
    assign wel         = wel_q;
    assign arr_wr_ok   = wel_q & ~in_region;
    assign sr_wr_ok    = wel_q & ~sr_locked;
endmodule

// File: rtl/spi_status_guard_chk.sv
module spi_status_guard_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       op_wren,
    input logic       op_wrdi,
    input logic       frame_end,
    input logic [1:0] frame_kind,
    input logic       sr_wr_valid,
    input logic       wp_n,
    input logic [7:0] status_byte,
    input logic       wel,
    input logic       arr_wr_ok,
    input logic       sr_wr_ok
);
    logic wclr;
    assign wclr = op_wrdi | (frame_end & ((frame_kind == 2'd1) | (frame_kind == 2'd2)));

    AST_WEL_SET: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (op_wren && !wclr) |=> wel); // R3
    AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wclr |=> !wel); // R4
    AST_WEL_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!op_wren && !wclr) |=> $stable(wel)); // R4
    AST_FULL_REGION: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (status_byte[3:2] == 2'b11) |-> !arr_wr_ok); // R5
    AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (sr_wr_valid && status_byte[7] && !wp_n) |=> $stable(status_byte[7:2])); // R6
    AST_NEEDS_WEL: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !wel |-> (!arr_wr_ok && !sr_wr_ok)); // R7
endmodule

bind spi_status_guard spi_status_guard_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .op_wren     (op_wren),
    .op_wrdi     (op_wrdi),
    .frame_end   (frame_end),
    .frame_kind  (frame_kind),
    .sr_wr_valid (sr_wr_valid),
    .wp_n        (wp_n),
    .status_byte (status_byte),
    .wel         (wel),
    .arr_wr_ok   (arr_wr_ok),
    .sr_wr_ok    (sr_wr_ok)
);

// File: tb/tb_spi_status_guard.sv
`timescale 1ns/1ps
module tb_spi_status_guard;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        op_wren = 1'b0, op_wrdi = 1'b0, frame_end = 1'b0;
    logic [1:0]  frame_kind = 2'd0;
    logic        sr_wr_valid = 1'b0;
    logic [7:0]  sr_wr_data = 8'h00;
    logic        wp_n = 1'b1;
    logic [15:0] wr_addr = 16'h0000;
    logic [7:0]  status_byte;
    logic        wel, arr_wr_ok, sr_wr_ok;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    spi_status_guard #(.ADDR_W(16)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .op_wren(op_wren), .op_wrdi(op_wrdi),
        .frame_end(frame_end), .frame_kind(frame_kind),
        .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data),
        .wp_n(wp_n), .wr_addr(wr_addr),
        .status_byte(status_byte), .wel(wel),
        .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wren();
        op_wren = 1'b1; @(negedge clk); op_wren = 1'b0;
    endtask
    task automatic wrdi();
        op_wrdi = 1'b1; @(negedge clk); op_wrdi = 1'b0;
    endtask
    task automatic fend(input logic [1:0] k);
        frame_end = 1'b1; frame_kind = k; @(negedge clk); frame_end = 1'b0; frame_kind = 2'd0;
    endtask
    task automatic srdata(input logic [7:0] d);
        sr_wr_valid = 1'b1; sr_wr_data = d; @(negedge clk); sr_wr_valid = 1'b0; sr_wr_data = 8'h00;
    endtask
    task automatic set_status(input logic [7:0] d);
        wren(); srdata(d); fend(2'd2);
    endtask
    task automatic probe(input string req, input logic [15:0] a, input logic exp);
        wr_addr = a; #1;
        check(req, $sformatf("arr_wr_ok @%h", a), {7'd0, arr_wr_ok}, {7'd0, exp});
    endtask

    task automatic t_reset();
        check("R1", "status after power-on", status_byte, 8'h00);
        check("R7", "permits with latch clear", {6'd0, arr_wr_ok, sr_wr_ok}, 8'h00);
    endtask

    task automatic t_latch();
        wren();
        check("R3", "status after enable", status_byte, 8'h02);
        fend(2'd0);
        check("R4", "latch kept after read frame", status_byte, 8'h02);
        wrdi();
        check("R4", "latch after disable", status_byte, 8'h00);
        wren(); fend(2'd1);
        check("R4", "latch after array-write frame", status_byte, 8'h00);
        op_wren = 1'b1; op_wrdi = 1'b1; @(negedge clk); op_wren = 1'b0; op_wrdi = 1'b0;
        check("R4", "clear wins over set", {7'd0, wel}, 8'h00);
    endtask

    task automatic t_status_write();
        wren(); srdata(8'h08);
        check("R6", "status after data byte", status_byte, 8'h0A);
        fend(2'd2);
        check("R6", "status after status frame", status_byte, 8'h08);
        set_status(8'h73);
        check("R6", "reserved bits ignored", status_byte, 8'h00);
    endtask

    task automatic t_regions();
        set_status(8'h08); wren();
        probe("R2", 16'h7FFF, 1'b1);
        probe("R2", 16'h8000, 1'b0);
        wp_n = 1'b0; probe("R5", 16'h1000, 1'b1); wp_n = 1'b1;
        fend(2'd0); srdata(8'h04); fend(2'd2); wren();
        probe("R2", 16'hBFFF, 1'b1);
        probe("R2", 16'hC000, 1'b0);
        fend(2'd0); srdata(8'h0C); fend(2'd2); wren();
        probe("R2", 16'h0000, 1'b0);
        fend(2'd0); srdata(8'h00); fend(2'd2); wren();
        probe("R2", 16'hFFFF, 1'b1);
        wrdi();
        probe("R7", 16'h0000, 1'b0);
    endtask

    task automatic t_lock();
        set_status(8'h80);
        check("R6", "lock flag set", status_byte, 8'h80);
        wp_n = 1'b0; wren(); #1;
        check("R6", "sr_wr_ok when locked", {7'd0, sr_wr_ok}, 8'h00);
        probe("R5", 16'hFFFF, 1'b1);
        srdata(8'h0C); fend(2'd2);
        check("R6", "blocked status write", status_byte, 8'h80);
        wp_n = 1'b1; set_status(8'h08);
        check("R6", "status write after pin high", status_byte, 8'h08);
        srdata(8'h8C);
        check("R7", "status write without latch", status_byte, 8'h08);
    endtask

    task automatic t_resets();
        set_status(8'h84); wren();
        check("R8", "before soft reset", status_byte, 8'h86);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R8", "after soft reset", status_byte, 8'h84);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
        check("R8", "after power-on reset", status_byte, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_status_write();
        t_regions();
        t_lock();
        t_resets();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule